// File: doc/BRIEF.md
# Vector Replay Stimulus Generator

This block plays back a constant table of samples fixed when the design is elaborated. The table is one packed parameter. After a synchronous reset is released, the block presents one entry per clock cycle, in table order, on its data output. When the final entry is reached, the block holds it there for every later cycle. It does not wrap back to the start and does not go idle.

The block suits simple stimulus sources inside a larger design or bench. Examples are a fixed sequence for a datapath under test, or a power-on configuration stream. It needs no memory port and no file access. Reset is its only control: asserting reset at any time starts the playback again from the first entry.

Top module: `vector_replay`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the read index returns to 0. After that edge, `sample` shows entry 0. Reset is synchronous: asserting `rst` changes nothing until the next rising edge.
- R2: Entry 0 is on `sample` in the first cycle after `rst` is released, before the next rising edge.
- R3: At each rising edge with `rst` low, the output moves from entry k to entry k+1, in table order, until the last entry is reached.
- R4: Once entry DEPTH-1 is shown, `sample` keeps that value on every later cycle while `rst` stays low.
- R5: The read index never exceeds DEPTH-1.
- R6: Entry k of the table sits at bits [k*SAMPLE_W +: SAMPLE_W] of `TABLE`, so entry 0 occupies the least significant bits.
- R7: With a one-entry table (DEPTH = 1), `sample` shows that single entry on every cycle, during reset and after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; restarts playback at entry 0 |
| sample | output | SAMPLE_W | Table entry currently being presented |

## Verification
The hardest state to reach from the ports is the hold after saturation. The bench has to show that the index stays pinned at the last entry for a long stretch and neither wraps nor drifts. It runs the default eleven-entry table for several times its length beyond the end and compares every cycle with the capped expected value. A reset applied partway through playback checks that the restart is synchronous. A second instance with a single entry covers the case where the last entry and the first entry are the same.

// File: rtl/replay_pkg.sv
package replay_pkg;

  // Index width able to hold 0..depth-1, never less than one bit.
  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Saturating step: stays on the final index, else moves forward by one.
  function automatic int unsigned step_index(input int unsigned cur,
                                             input int unsigned last);
    return (cur >= last) ? last : cur + 1;
  endfunction

endpackage

// File: rtl/replay_index_ctr.sv
module replay_index_ctr #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx,
  output logic             at_last,
  output logic             advance
);
  import replay_pkg::*;

  localparam int unsigned LAST = DEPTH - 1;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  assign at_last = (idx_q == IDX_W'(LAST));
  assign advance = !rst && !at_last;
  assign idx_d   = IDX_W'(step_index(int'(idx_q), LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;
endmodule

// File: rtl/replay_table_sel.sv
module replay_table_sel #(
  parameter int unsigned           DEPTH    = 11,
  parameter int unsigned           SAMPLE_W = 8,
  parameter int unsigned           IDX_W    = 4,
  parameter logic [DEPTH*SAMPLE_W-1:0] TABLE = '0
) (
  input  logic [IDX_W-1:0]    idx,
  output logic [SAMPLE_W-1:0] data
);
  logic [SAMPLE_W-1:0] entry [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign entry[k] = TABLE[k*SAMPLE_W +: SAMPLE_W];
  end

  if (DEPTH == 1) begin : g_single
    assign data = entry[0];
  end else begin : g_multi
    always_comb begin
      data = entry[DEPTH-1];
      for (int k = 0; k < DEPTH; k++) begin
        if (idx == IDX_W'(k)) data = entry[k];
      end
    end
  end
endmodule

// File: rtl/vector_replay.sv
module vector_replay #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned DEPTH    = 11,
  parameter logic [DEPTH*SAMPLE_W-1:0] TABLE = {
    8'd21, 8'd19, 8'd17, 8'd15, 8'd13, 8'd11,
    8'd9,  8'd7,  8'd5,  8'd3,  8'd1
  }
) (
  input  logic                clk,
  input  logic                rst,
  output logic [SAMPLE_W-1:0] sample
);
  import replay_pkg::*;

  localparam int unsigned IDX_W = idx_width(DEPTH);

  logic [IDX_W-1:0] idx;
  logic             at_last;
  logic             advance;

  replay_index_ctr #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .idx    (idx),
    .at_last(at_last),
    .advance(advance)
  );

  replay_table_sel #(
    .DEPTH   (DEPTH),
    .SAMPLE_W(SAMPLE_W),
    .IDX_W   (IDX_W),
    .TABLE   (TABLE)
  ) u_sel (
    .idx (idx),
    .data(sample)
  );
endmodule

// File: rtl/vector_replay_chk.sv
module vector_replay_chk #(
  parameter int unsigned DEPTH    = 11,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [IDX_W-1:0]    idx,
  input logic                at_last,
  input logic                advance,
  input logic [SAMPLE_W-1:0] sample
);
  // R1: a reset edge leaves the index at zero
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> (idx == '0));

  // R3: each running edge before the end moves the index forward by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    advance |=> (idx == $past(idx) + 1'b1));

  // R4: once at the final entry, the output and index stay put
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    at_last |=> (at_last && $stable(sample)));

  // R5: index stays inside the table
  p_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(idx) <= int'(DEPTH - 1)));
endmodule

bind vector_replay vector_replay_chk #(
  .DEPTH   (DEPTH),
  .IDX_W   (IDX_W),
  .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .idx    (idx),
  .at_last(at_last),
  .advance(advance),
  .sample (sample)
);

// File: tb/sim_vector_replay.sv
module sim_vector_replay;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sample;
  logic [3:0] sample1;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vector_replay u0 (.clk(clk), .rst(rst), .sample(sample));

  vector_replay #(.SAMPLE_W(4), .DEPTH(1), .TABLE(4'hA)) u1 (
    .clk(clk), .rst(rst), .sample(sample1));

  // Expected entry k of the default table: odd numbers 1..21, capped at the last.
  function automatic logic [7:0] expect_at(input int k);
    int c = (k > N - 1) ? N - 1 : k;
    return 8'(2 * c + 1);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset shows entry 0", sample, 8'd1);
    check("R7 single entry in reset", {4'h0, sample1}, 8'h0A);
  endtask

  task automatic t_playback();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2 first cycle after release", sample, expect_at(0));
    for (int k = 1; k < 13; k++) begin
      @(negedge clk);
      check("R3 R6 in-order playback", sample, expect_at(k));
      check("R7 single entry running", {4'h0, sample1}, 8'h0A);
    end
  endtask

  task automatic t_hold();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check("R4 hold last entry", sample, 8'd21);
    end
  endtask

  task automatic t_midreset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      check("R3 replay after reset", sample, expect_at(k));
    end
    rst = 1'b1;
    #1;
    check("R1 reset is synchronous", sample, expect_at(4));
    @(negedge clk);
    check("R1 mid-run reset to entry 0", sample, expect_at(0));
    rst = 1'b0;
    for (int k = 1; k < 15; k++) begin
      @(negedge clk);
      check("R4 R5 playback saturates again", sample, expect_at(k));
    end
  endtask

  initial begin
    t_reset();
    t_playback();
    t_hold();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule